// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier with Parallel Test Mode

This block sits on the device side of a dynamic memory and works out what each row-strobe cycle is for. It watches the active-low row strobe, column strobe and write strobe and samples them on a fast internal clock. From the order in which they move, it labels each cycle as one of five kinds: a normal access, a refresh of an externally supplied row, a refresh driven by the internal counter, a hidden refresh folded into a held read, or an entry into test mode. For every refresh it raises a one-clock strobe and gives the row to refresh. For the counter-driven kinds, that row comes from an internal 11-bit counter that steps forward afterwards.

The device has a latched two-bit parallel test mode. While it is on, each data output bit of a read shows whether the two internal cell bits behind it agree. The column-select bit that would normally choose between those two bits no longer matters. In normal mode the data outputs carry the selected cell bit. The read data is held while the column strobe stays low, and this includes the time a hidden refresh runs underneath it.

Strobes and address pass through two synchronising flops. Every result appears at the pins three clock edges after the strobe edge that decides it. The data and status pins are plain, registered outputs. They have no handshake and no back-pressure, because the external strobes set the pace and cannot be stalled.

Top module: `dram_cycle_decoder`

## Requirements
- R1: If the column strobe is low and the write strobe is high when the row strobe falls, the cycle is a counter refresh. It reports type 3, pulses `refresh`, puts the counter value on `row_sel`, and then advances the counter by one.
- R2: If the column strobe is high when the row strobe falls and does not fall before the row strobe rises, the cycle is an address refresh. It is reported at the row strobe rise with type 2, a `refresh` pulse, and the row address captured at the fall on `row_sel`.
- R3: If the column strobe falls while a cycle that began with it high is still open, the cycle is an access. It is reported with type 1 and the captured row on `row_sel`, and it gives no `refresh` pulse.
- R4: If both the column strobe and the write strobe are low when the row strobe falls, the cycle is a test entry. It reports type 5, refreshes and advances the counter like R1, and sets `test_mode`. The flag then stays set through later access cycles.
- R5: An address refresh, a counter refresh with the write strobe high, or a hidden refresh clears `test_mode`.
- R6: In a test-mode read, output bit i is 1 exactly when `cells[2i]` equals `cells[2i+1]`. Address bit 9 has no effect.
- R7: In a normal read, output bit i is `cells[2i+1]` when address bit 9 was high at the column strobe fall, and `cells[2i]` otherwise. `dq_en` rises with the access report and falls after the column strobe rises. If the write strobe is low at the column strobe fall, `dq_en` stays low.
- R8: If the row strobe falls again while the column strobe has stayed low since a read, the cycle is a hidden refresh. It reports type 4 and refreshes from the counter, and `dq_en` and `dq` keep their read values throughout.
- R9: The refresh counter is 11 bits wide, covers 2048 rows and wraps from 2047 to 0.
- R10: After reset the counter is 0, `test_mode` is 0, and `cyc_valid`, `refresh` and `dq_en` are 0.
- R11: The cycle type codes are: 0 none, 1 access, 2 address refresh, 3 counter refresh, 4 hidden refresh, 5 test entry. They are valid whenever `cyc_valid` is high, and every classification shows on the pins three clocks after the deciding strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Multiplexed row/column address; bit 9 is the column pair select |
| cells | input | 16 | Internal cell bits read for the current column, two per output bit |
| cyc_valid | output | 1 | One-clock pulse when a cycle has been classified |
| cyc_type | output | 3 | Cycle type code (R11) |
| refresh | output | 1 | One-clock refresh strobe |
| row_sel | output | 11 | Row for the classified cycle |
| test_mode | output | 1 | Latched parallel test mode flag |
| dq_en | output | 1 | Read data drive enable |
| dq | output | 8 | Read data, or per-pair compare results in test mode |

## Verification
A hidden refresh and a held read overlap in time: the refresh strobe, the counter row and the mode clear all happen while the read data must not move. The bench leaves the column strobe low after a read and drops the row strobe again. Before that second fall it flips every cell input. The scoreboard then expects a type 4 report carrying the counter row, and a direct check confirms that `dq_en` is still high and `dq` still holds the value computed for the original cells.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CY_NONE   = 3'd0,
    CY_ACCESS = 3'd1,
    CY_ROR    = 3'd2,
    CY_CBR    = 3'd3,
    CY_HIDDEN = 3'd4,
    CY_TENTER = 3'd5
  } cyc_e;
endpackage

// File: rtl/dcd_sync.sv
// Two-flop synchroniser for a group of slow, held inputs.
module dcd_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcd_refcnt.sv
// Internal refresh row counter; wraps at 2**ROW_W.
module dcd_refcnt #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  // R9: one step per counter refresh, modulo the row count
  a_r9_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt == $past(cnt) + 1'b1);
  a_r9_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt));
endmodule

// File: rtl/dcd_testcmp.sv
// Per output bit: pair compare in test mode, pair select otherwise.
module dcd_testcmp #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] cells,
  input  logic            test_on,
  input  logic            col_hi,
  output logic [DW-1:0]   dq_next
);
  for (genvar i = 0; i < DW; i++) begin : g_pair
    always_comb begin
      if (test_on) dq_next[i] = (cells[2*i] == cells[2*i+1]);
      else         dq_next[i] = col_hi ? cells[2*i+1] : cells[2*i];
    end
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int DW      = 8,
  parameter int COL_BIT = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [2*DW-1:0] cells,
  output logic            cyc_valid,
  output logic [2:0]      cyc_type,
  output logic            refresh,
  output logic [ROW_W-1:0] row_sel,
  output logic            test_mode,
  output logic            dq_en,
  output logic [DW-1:0]   dq
);
  localparam int NSTB = 3;

  logic [NSTB-1:0]  stb_s;
  logic             ras_s, cas_s, we_s;
  logic             ras_d, cas_d;
  logic [ROW_W-1:0] addr_s;
  logic [ROW_W-1:0] cnt;
  logic [ROW_W-1:0] row_q;
  logic [DW-1:0]    dq_next;
  logic             pend;      // cycle opened with column strobe high, undecided
  logic             held;      // column strobe low continuously since a read
  logic             ras_fall, ras_rise, cas_fall, cas_rise, adv;

  dcd_sync #(.W(NSTB), .RST_VAL({NSTB{1'b1}})) i_stb_sync (
    .clk(clk), .rst_n(rst_n), .d({ras_n, cas_n, we_n}), .q(stb_s));
  assign {ras_s, cas_s, we_s} = stb_s;

  dcd_sync #(.W(ROW_W), .RST_VAL('0)) i_addr_sync (
    .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));

  assign ras_fall = ras_d & ~ras_s;
  assign ras_rise = ~ras_d & ras_s;
  assign cas_fall = cas_d & ~cas_s;
  assign cas_rise = ~cas_d & cas_s;
  assign adv      = ras_fall & ~cas_s;

  dcd_refcnt #(.ROW_W(ROW_W)) i_refcnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cnt(cnt));

  dcd_testcmp #(.DW(DW)) i_cmp (
    .cells(cells), .test_on(test_mode), .col_hi(addr_s[COL_BIT]), .dq_next(dq_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_d     <= 1'b1;
      cas_d     <= 1'b1;
      pend      <= 1'b0;
      held      <= 1'b0;
      row_q     <= '0;
      cyc_valid <= 1'b0;
      cyc_type  <= CY_NONE;
      refresh   <= 1'b0;
      row_sel   <= '0;
      test_mode <= 1'b0;
      dq_en     <= 1'b0;
      dq        <= '0;
    end else begin
      ras_d     <= ras_s;
      cas_d     <= cas_s;
      cyc_valid <= 1'b0;
      refresh   <= 1'b0;
      if (cas_rise) begin
        held  <= 1'b0;
        dq_en <= 1'b0;
      end
      if (ras_fall) begin
        if (!cas_s) begin
          cyc_valid <= 1'b1;
          refresh   <= 1'b1;
          row_sel   <= cnt;
          if (!we_s) begin
            cyc_type  <= CY_TENTER;
            test_mode <= 1'b1;
          end else begin
            cyc_type  <= held ? CY_HIDDEN : CY_CBR;
            test_mode <= 1'b0;
          end
        end else begin
          pend  <= 1'b1;
          row_q <= addr_s;
        end
      end else if (pend && ras_rise) begin
        pend      <= 1'b0;
        cyc_valid <= 1'b1;
        cyc_type  <= CY_ROR;
        refresh   <= 1'b1;
        row_sel   <= row_q;
        test_mode <= 1'b0;
      end else if (pend && cas_fall && !ras_s) begin
        pend      <= 1'b0;
        cyc_valid <= 1'b1;
        cyc_type  <= CY_ACCESS;
        row_sel   <= row_q;
        if (we_s) begin
          held  <= 1'b1;
          dq_en <= 1'b1;
          dq    <= dq_next;
        end
      end
    end
  end

  // R1: a refresh strobe never comes without a classification
  a_r1_refresh_classified: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> cyc_valid);
  // R3: access cycles never refresh
  a_r3_access_no_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == CY_ACCESS) |-> !refresh);
  // R4: test entry leaves the mode set
  a_r4_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == CY_TENTER) |-> test_mode);
  // R5: exit cycles leave the mode clear
  a_r5_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_type == CY_ROR || cyc_type == CY_CBR || cyc_type == CY_HIDDEN))
      |-> !test_mode);
  // R8: hidden refresh keeps the read data on the outputs
  a_r8_hidden_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == CY_HIDDEN) |-> (dq_en && $stable(dq)));
endmodule

// File: tb/test_dram_cycle_decoder.sv
module test_dram_cycle_decoder;
  localparam logic [2:0] T_ACC = 3'd1, T_ROR = 3'd2, T_CBR = 3'd3,
                         T_HID = 3'd4, T_ENT = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] cells = '0;
  logic cyc_valid, refresh, test_mode, dq_en;
  logic [2:0] cyc_type;
  logic [10:0] row_sel;
  logic [7:0] dq;

  int checks = 0;
  int errors = 0;
  logic [10:0] m_cnt = '0;
  logic m_test = 1'b0;

  typedef struct {
    logic [2:0]  t;
    logic [10:0] r;
    logic        f;
    logic        tm;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  dram_cycle_decoder i_dram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cells(cells), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .refresh(refresh), .row_sel(row_sel), .test_mode(test_mode),
    .dq_en(dq_en), .dq(dq));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_dq(input logic [15:0] c, input logic col9, input logic tm);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = tm ? (c[2*i] == c[2*i+1]) : (col9 ? c[2*i+1] : c[2*i]);
    return r;
  endfunction

  function automatic void push(input logic [2:0] t, input logic [10:0] r,
                               input logic f, input logic tm);
    exp_t e;
    e.t = t; e.r = r; e.f = f; e.tm = tm;
    q.push_back(e);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cyc_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected cycle report type %0d row %0h", cyc_type, row_sel);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (cyc_type !== e.t || row_sel !== e.r || refresh !== e.f || test_mode !== e.tm) begin
          errors++;
          $display("FAIL R1-class report actual t%0d r%0h f%0b m%0b expected t%0d r%0h f%0b m%0b",
                   cyc_type, row_sel, refresh, test_mode, e.t, e.r, e.f, e.tm);
        end
      end
    end
  end

  // R1 / R4: counter refresh, with write strobe low it enters test mode
  task automatic do_cbr(input logic we_low);
    m_test = we_low;
    push(we_low ? T_ENT : T_CBR, m_cnt, 1'b1, m_test);
    m_cnt = m_cnt + 1'b1;
    cas_n = 1'b0; we_n = ~we_low; wclk(3);
    ras_n = 1'b0; wclk(5);
    ras_n = 1'b1; wclk(2);
    cas_n = 1'b1; we_n = 1'b1; wclk(4);
  endtask

  // R2: address refresh
  task automatic do_ror(input logic [10:0] row);
    m_test = 1'b0;
    push(T_ROR, row, 1'b1, 1'b0);
    addr = row; wclk(3);
    ras_n = 1'b0; wclk(6);
    ras_n = 1'b1; wclk(5);
  endtask

  // R3 / R6 / R7: read access; optionally leaves CAS low
  task automatic do_read(input logic [10:0] row, input logic col9,
                         input logic [15:0] cv, input logic release_cas, input string req);
    push(T_ACC, row, 1'b0, m_test);
    addr = row; wclk(3);
    ras_n = 1'b0; wclk(4);
    addr = {1'b0, col9, 9'h055}; cells = cv; wclk(3);
    cas_n = 1'b0; wclk(6);
    chk({req, " dq_en"}, {31'd0, dq_en}, 32'd1);
    chk({req, " dq"}, {24'd0, dq}, {24'd0, exp_dq(cv, col9, m_test)});
    if (release_cas) begin
      ras_n = 1'b1; wclk(3);
      cas_n = 1'b1; wclk(5);
      chk("R7 dq_en off", {31'd0, dq_en}, 32'd0);
    end
  endtask

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    // R10 reset state
    chk("R10 cyc_valid", {31'd0, cyc_valid}, 32'd0);
    chk("R10 test_mode", {31'd0, test_mode}, 32'd0);
    chk("R10 dq_en", {31'd0, dq_en}, 32'd0);
    chk("R10 refresh", {31'd0, refresh}, 32'd0);

    do_cbr(1'b0);   // R1, R10: first counter row is 0
    do_cbr(1'b0);
    do_ror(11'h155); // R2
    do_read(11'h2AA, 1'b0, 16'hA5C3, 1'b1, "R7 lo");  // R3, R7
    do_read(11'h0F0, 1'b1, 16'hA5C3, 1'b1, "R7 hi");

    // R7 write: no data drive
    push(T_ACC, 11'h033, 1'b0, m_test);
    addr = 11'h033; wclk(3);
    ras_n = 1'b0; wclk(4);
    we_n = 1'b0; wclk(3);
    cas_n = 1'b0; wclk(6);
    chk("R7 write no dq_en", {31'd0, dq_en}, 32'd0);
    ras_n = 1'b1; wclk(3);
    cas_n = 1'b1; we_n = 1'b1; wclk(5);

    do_cbr(1'b1);   // R4 enter
    chk("R4 mode set", {31'd0, test_mode}, 32'd1);
    do_read(11'h101, 1'b0, 16'hC3F0, 1'b1, "R6 col0");  // R6, R4 stays
    do_read(11'h101, 1'b1, 16'hC3F0, 1'b1, "R6 col1");
    chk("R4 mode kept", {31'd0, test_mode}, 32'd1);
    do_ror(11'h7FF); // R5 exit by address refresh
    chk("R5 ror exit", {31'd0, test_mode}, 32'd0);
    do_cbr(1'b1);
    do_cbr(1'b0);   // R5 exit by counter refresh
    chk("R5 cbr exit", {31'd0, test_mode}, 32'd0);

    // R8 hidden refresh under a held read
    begin
      logic [7:0] held_dq;
      held_dq = exp_dq(16'h9A3C, 1'b1, 1'b0);
      do_read(11'h444, 1'b1, 16'h9A3C, 1'b0, "R8 read");
      ras_n = 1'b1; wclk(4);
      cells = ~cells;
      push(T_HID, m_cnt, 1'b1, 1'b0);
      m_cnt = m_cnt + 1'b1;
      ras_n = 1'b0; wclk(6);
      chk("R8 dq_en held", {31'd0, dq_en}, 32'd1);
      chk("R8 dq held", {24'd0, dq}, {24'd0, held_dq});
      ras_n = 1'b1; wclk(3);
      cas_n = 1'b1; wclk(5);
    end

    // R9 wrap: run past row 2047
    for (int k = 0; k < 2050; k++) do_cbr(1'b0);
    chk("R9 model wrapped", {21'd0, m_cnt}, 32'd8);

    wclk(10);
    chk("R11 all reports seen", q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule